// File: doc/BRIEF.md
# Magic Packet Wake Detector

This block watches the received byte stream of a network port while the system sleeps. It looks for a wake pattern anywhere inside a frame. The pattern is a run of six 0xFF bytes followed directly by sixteen unbroken copies of the station's 6-byte address. A pattern found part-way through a frame is only held as a candidate. It becomes a wake event only when that frame closes with its good flag set, so a damaged frame can never wake the host.

The receive path feeds the block one byte per cycle, marked with valid, first-byte and last-byte flags, and gives a frame-good flag with the last byte. The detector scans only while both the pattern-wake enable and the global power-management enable are high. A detected event sets a sticky flag, which drives an active-low event pin. Software clears the flag. A mode input selects whether only software may clear it, or whether dropping the global enable also clears it.

Top module: `magic_wake_det`

## Requirements
- R1: The pattern is SYNC_LEN (6) bytes of 0xFF followed by COPIES (16) back-to-back copies of the station address; each copy is sent most significant byte first, so `stationAddr[47:40]` is the first byte of a copy.
- R2: The pattern is recognised at any byte offset within a frame, whatever bytes come before it.
- R3: A completed pattern sets `wakeEvent` only when that frame's last byte arrives with `frameGood` high, including when the pattern ends on that last byte; the flag is visible in the cycle after that byte is taken. If `frameGood` is low, the candidate is dropped.
- R4: While `magicEn` or `pmEn` is low, no byte is scanned and `wakeEvent` cannot be set.
- R5: After the sync run has completed, further 0xFF bytes before the first address byte keep the detector synchronised. If the first address byte is itself 0xFF, such a byte is taken as that address byte instead.
- R6: A byte that breaks an address copy sends the detector back to hunting for the sync run, and that same byte counts as the first byte of a new run if it is 0xFF.
- R7: A byte flagged `frameStart` begins scanning from a cleared state, so a partial match from an unfinished earlier frame does not carry over.
- R8: `wakeEvent` is sticky and `pmeN` is its inverse; a pulse on `swClear` clears it from the next cycle. If a commit falls in the same cycle as the clear, the commit wins.
- R9: With `swOnly` high, only `swClear` clears `wakeEvent`; with `swOnly` low, `pmEn` low also clears it.
- R10: A sync run shorter than SYNC_LEN, or fewer than COPIES address copies, yields no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| byteData | input | 8 | Received byte |
| byteValid | input | 1 | byteData holds a frame byte this cycle |
| frameStart | input | 1 | The current byte is the first of a frame |
| frameEnd | input | 1 | The current byte is the last of a frame |
| frameGood | input | 1 | With frameEnd: the frame passed its checks |
| stationAddr | input | 48 | Station address, first-sent byte in the top bits |
| magicEn | input | 1 | Pattern wake enable |
| pmEn | input | 1 | Global power-management enable |
| swClear | input | 1 | Software clear of the event flag |
| swOnly | input | 1 | 1: only software clears the flag |
| wakeEvent | output | 1 | Sticky wake event flag |
| pmeN | output | 1 | Active-low power-management event |

## Verification
The assertions assume that `frameStart` and `frameEnd` are only meaningful while `byteValid` is high. They also assume that the station address and the enables are held steady for the length of a frame, apart from deliberate enable tests. The stimulus drives every flag at the falling edge, together with `byteValid`. It changes the address and the enables only between frames, with the bus idle, and sends one idle cycle after every frame. Clear pulses are sent only while no frame end is being taken, so the clear-then-low property is never tested against a same-cycle commit.

// File: rtl/mpw_pkg.sv
package mpw_pkg;

  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_ADDR = 2'd1,
    ST_HIT  = 2'd2
  } scan_e;

  // strobes from control to datapath
  typedef struct packed {
    logic fresh;      // byte opens a new frame: evaluate from cleared counters
    logic syncInc;
    logic syncLoad1;
    logic syncClr;
    logic addrInc;
    logic addrClr;
  } dp_ctl_t;

endpackage

// File: rtl/mpw_datapath.sv
module mpw_datapath
  import mpw_pkg::*;
#(
  parameter int SYNC_LEN   = 6,
  parameter int COPIES     = 16,
  parameter int ADDR_BYTES = 6
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [7:0]              byteData,
  input  logic [ADDR_BYTES*8-1:0] stationAddr,
  input  dp_ctl_t                 ctl,
  output logic                    isFF,
  output logic                    addrHit,
  output logic                    syncFull,
  output logic                    addrFirst,
  output logic                    addrLast
);

  localparam int SW = $clog2(SYNC_LEN + 1);
  localparam int BW = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
  localparam int CW = (COPIES > 1) ? $clog2(COPIES) : 1;

  logic [SW-1:0] syncCnt, effSync;
  logic [BW-1:0] byteIdx, effByte;
  logic [CW-1:0] copyIdx, effCopy;
  logic [7:0]    addrBytes [ADDR_BYTES];
  logic [7:0]    expByte;

  // split the address into bytes, first-sent byte at index 0
  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_addr
    assign addrBytes[g] = stationAddr[(ADDR_BYTES-g)*8-1 -: 8];
  end

  always_comb begin
    effSync = ctl.fresh ? '0 : syncCnt;
    effByte = ctl.fresh ? '0 : byteIdx;
    effCopy = ctl.fresh ? '0 : copyIdx;
    expByte = addrBytes[effByte];
  end

  assign isFF      = (byteData == 8'hFF);
  assign addrHit   = (byteData == expByte);
  assign syncFull  = (effSync == SW'(SYNC_LEN - 1));
  assign addrFirst = (effByte == '0) && (effCopy == '0);
  assign addrLast  = (effByte == BW'(ADDR_BYTES - 1)) && (effCopy == CW'(COPIES - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncCnt <= '0;
    end else if (ctl.syncClr) begin
      syncCnt <= '0;
    end else if (ctl.syncLoad1) begin
      syncCnt <= SW'(1);
    end else if (ctl.syncInc) begin
      syncCnt <= effSync + SW'(1);
    end else if (ctl.fresh) begin
      syncCnt <= '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteIdx <= '0;
      copyIdx <= '0;
    end else if (ctl.addrClr) begin
      byteIdx <= '0;
      copyIdx <= '0;
    end else if (ctl.addrInc) begin
      if (effByte == BW'(ADDR_BYTES - 1)) begin
        byteIdx <= '0;
        copyIdx <= effCopy + CW'(1);
      end else begin
        byteIdx <= effByte + BW'(1);
        copyIdx <= effCopy;
      end
    end else if (ctl.fresh) begin
      byteIdx <= '0;
      copyIdx <= '0;
    end
  end

  // R1: position counters stay inside one pattern
  a_r1_byte_range: assert property (@(posedge clk) disable iff (!rstN)
    byteIdx < BW'(ADDR_BYTES));
  a_r1_copy_range: assert property (@(posedge clk) disable iff (!rstN)
    int'(copyIdx) < COPIES);
  // R10: sync run never counts past its full length
  a_r10_sync_range: assert property (@(posedge clk) disable iff (!rstN)
    int'(syncCnt) < SYNC_LEN);
  // R6: a re-evaluated sync byte restarts the run at one
  a_r6_reload_one: assert property (@(posedge clk) disable iff (!rstN)
    ctl.syncLoad1 && !ctl.syncClr |=> syncCnt == SW'(1));

endmodule

// File: rtl/mpw_control.sv
module mpw_control
  import mpw_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    byteValid,
  input  logic    frameStart,
  input  logic    frameEnd,
  input  logic    frameGood,
  input  logic    magicEn,
  input  logic    pmEn,
  input  logic    swClear,
  input  logic    swOnly,
  input  logic    isFF,
  input  logic    addrHit,
  input  logic    syncFull,
  input  logic    addrFirst,
  input  logic    addrLast,
  output dp_ctl_t ctl,
  output logic    wakeEvent
);

  scan_e st, nxt, cur;
  logic  inFrame;
  logic  active, take, hitNow, commit;

  always_comb begin
    active = magicEn & pmEn;
    take   = byteValid & (inFrame | frameStart) & active;
    ctl    = '0;
    ctl.fresh = take & frameStart;
    cur    = frameStart ? ST_HUNT : st;
    nxt    = st;
    hitNow = 1'b0;
    commit = 1'b0;
    if (!active) begin
      nxt         = ST_HUNT;
      ctl.syncClr = 1'b1;
      ctl.addrClr = 1'b1;
    end else if (take) begin
      nxt = cur;
      unique case (cur)
        ST_HUNT: begin
          ctl.addrClr = 1'b1;
          if (isFF) begin
            if (syncFull) begin
              nxt         = ST_ADDR;
              ctl.syncClr = 1'b1;
            end else begin
              ctl.syncInc = 1'b1;
            end
          end else begin
            ctl.syncClr = 1'b1;
          end
        end
        ST_ADDR: begin
          if (addrHit) begin
            if (addrLast) begin
              nxt         = ST_HIT;
              hitNow      = 1'b1;
              ctl.addrClr = 1'b1;
            end else begin
              ctl.addrInc = 1'b1;
            end
          end else if (isFF && addrFirst) begin
            nxt = ST_ADDR;              // extra sync byte, stay locked
          end else begin
            nxt         = ST_HUNT;
            ctl.addrClr = 1'b1;
            if (isFF) ctl.syncLoad1 = 1'b1;
            else      ctl.syncClr   = 1'b1;
          end
        end
        ST_HIT: hitNow = 1'b1;
        default: nxt = ST_HUNT;
      endcase
      if (frameEnd) begin
        commit        = hitNow & frameGood;
        nxt           = ST_HUNT;
        ctl.syncLoad1 = 1'b0;
        ctl.syncInc   = 1'b0;
        ctl.addrInc   = 1'b0;
        ctl.syncClr   = 1'b1;
        ctl.addrClr   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= ST_HUNT;
    else       st <= nxt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inFrame <= 1'b0;
    end else if (byteValid) begin
      if (frameEnd)        inFrame <= 1'b0;
      else if (frameStart) inFrame <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wakeEvent <= 1'b0;
    end else if (commit) begin
      wakeEvent <= 1'b1;
    end else if (swClear) begin
      wakeEvent <= 1'b0;
    end else if (!swOnly && !pmEn) begin
      wakeEvent <= 1'b0;
    end
  end

  // R3: an event only appears after a good frame end
  a_r3_rise_on_good_end: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wakeEvent) |-> $past(byteValid && frameEnd && frameGood));
  // R4: disabled detector idles and never raises the flag
  a_r4_idle_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !(magicEn && pmEn) |=> st == ST_HUNT);
  a_r4_no_set_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !(magicEn && pmEn) && !wakeEvent |=> !wakeEvent);
  // R8: clear takes effect next cycle when no frame end competes
  a_r8_clear: assert property (@(posedge clk) disable iff (!rstN)
    swClear && !(byteValid && frameEnd) |=> !wakeEvent);
  // R9: software-only mode holds the flag
  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    wakeEvent && swOnly && !swClear |=> wakeEvent);

endmodule

// File: rtl/magic_wake_det.sv
module magic_wake_det
  import mpw_pkg::*;
#(
  parameter int SYNC_LEN   = 6,
  parameter int COPIES     = 16,
  parameter int ADDR_BYTES = 6
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [7:0]              byteData,
  input  logic                    byteValid,
  input  logic                    frameStart,
  input  logic                    frameEnd,
  input  logic                    frameGood,
  input  logic [ADDR_BYTES*8-1:0] stationAddr,
  input  logic                    magicEn,
  input  logic                    pmEn,
  input  logic                    swClear,
  input  logic                    swOnly,
  output logic                    wakeEvent,
  output logic                    pmeN
);

  dp_ctl_t ctl;
  logic    isFF, addrHit, syncFull, addrFirst, addrLast;

  mpw_datapath #(
    .SYNC_LEN  (SYNC_LEN),
    .COPIES    (COPIES),
    .ADDR_BYTES(ADDR_BYTES)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .byteData   (byteData),
    .stationAddr(stationAddr),
    .ctl        (ctl),
    .isFF       (isFF),
    .addrHit    (addrHit),
    .syncFull   (syncFull),
    .addrFirst  (addrFirst),
    .addrLast   (addrLast)
  );

  mpw_control i_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .byteValid (byteValid),
    .frameStart(frameStart),
    .frameEnd  (frameEnd),
    .frameGood (frameGood),
    .magicEn   (magicEn),
    .pmEn      (pmEn),
    .swClear   (swClear),
    .swOnly    (swOnly),
    .isFF      (isFF),
    .addrHit   (addrHit),
    .syncFull  (syncFull),
    .addrFirst (addrFirst),
    .addrLast  (addrLast),
    .ctl       (ctl),
    .wakeEvent (wakeEvent)
  );

  assign pmeN = ~wakeEvent;

endmodule

// File: tb/test_magic_wake_det.sv
module test_magic_wake_det;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  byteData = '0;
  logic        byteValid = 1'b0, frameStart = 1'b0, frameEnd = 1'b0, frameGood = 1'b0;
  logic [47:0] stationAddr = 48'h02_1A_3C_4D_5E_6F;
  logic        magicEn = 1'b1, pmEn = 1'b1, swClear = 1'b0, swOnly = 1'b1;
  logic        wakeEvent, pmeN;

  int          checks = 0;
  int          errors = 0;
  bit          finished = 1'b0;
  logic [7:0]  frm[$];
  bit          expQ[$];
  string       tagQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  magic_wake_det i_magic_wake_det (
    .clk(clk), .rstN(rstN), .byteData(byteData), .byteValid(byteValid),
    .frameStart(frameStart), .frameEnd(frameEnd), .frameGood(frameGood),
    .stationAddr(stationAddr), .magicEn(magicEn), .pmEn(pmEn),
    .swClear(swClear), .swOnly(swOnly), .wakeEvent(wakeEvent), .pmeN(pmeN)
  );

  // monitor: pops one expectation per item and compares the outputs
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        automatic bit    e = expQ.pop_front();
        automatic string t = tagQ.pop_front();
        checks++;
        if (wakeEvent !== e || pmeN !== ~e) begin
          errors++;
          $display("FAIL %s: wakeEvent=%b pmeN=%b expected wakeEvent=%b pmeN=%b",
                   t, wakeEvent, pmeN, e, ~e);
        end
      end
    end
  end

  task automatic pushExp(input string tag, input bit e);
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  task automatic addFF(input int n);
    for (int i = 0; i < n; i++) frm.push_back(8'hFF);
  endtask

  task automatic addCopies(input int n);
    for (int c = 0; c < n; c++)
      for (int b = 0; b < 6; b++) frm.push_back(stationAddr[47-8*b -: 8]);
  endtask

  task automatic addJunk(input int n);
    for (int i = 0; i < n; i++) frm.push_back(8'h80 + 8'(i));
  endtask

  // driver: sends frm, optionally closes the frame, then pushes the expectation
  task automatic sendFrame(input bit good, input bit withEnd, input string tag, input bit e);
    for (int i = 0; i < frm.size(); i++) begin
      @(negedge clk);
      byteValid  = 1'b1;
      byteData   = frm[i];
      frameStart = (i == 0);
      frameEnd   = withEnd && (i == frm.size() - 1);
      frameGood  = good && withEnd && (i == frm.size() - 1);
    end
    @(negedge clk);
    byteValid = 1'b0; frameStart = 1'b0; frameEnd = 1'b0; frameGood = 1'b0;
    if (withEnd) pushExp(tag, e);
    @(negedge clk);
    frm.delete();
  endtask

  task automatic clearFlag(input string tag);
    @(negedge clk);
    swClear = 1'b1;
    @(negedge clk);
    swClear = 1'b0;
    pushExp(tag, 1'b0);
    @(negedge clk);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checks++;   // reset state
    if (wakeEvent !== 1'b0 || pmeN !== 1'b1) begin
      errors++;
      $display("FAIL R8 reset: wakeEvent=%b pmeN=%b expected 0 1", wakeEvent, pmeN);
    end

    // R1: pattern at offset 0, good frame
    addFF(6); addCopies(16); addJunk(4);
    sendFrame(1, 1, "R1 basic match", 1);
    clearFlag("R8 software clear");

    // R2: pattern after 17 junk bytes
    addJunk(17); addFF(6); addCopies(16); addJunk(3);
    sendFrame(1, 1, "R2 offset match", 1);
    clearFlag("R8 clear after offset");

    // R3: bad frame drops the candidate
    addFF(6); addCopies(16); addJunk(2);
    sendFrame(0, 1, "R3 bad frame", 0);

    // R3: pattern ends on last byte
    addJunk(5); addFF(6); addCopies(16);
    sendFrame(1, 1, "R3 end on last byte", 1);
    clearFlag("R8 clear after last-byte match");

    // R5: extra sync bytes
    addFF(9); addCopies(16); addJunk(1);
    sendFrame(1, 1, "R5 extra sync bytes", 1);
    clearFlag("R8 clear after extra sync");

    // R6: broken copy then recovery where breaking FF starts new run
    addFF(6); addCopies(2);
    frm.push_back(stationAddr[47:40]); frm.push_back(stationAddr[39:32]);
    addFF(6); addCopies(16); addJunk(1);
    sendFrame(1, 1, "R6 recover via re-evaluated FF", 1);
    clearFlag("R8 clear after recovery");

    // R6: broken copy without restart gives nothing
    addFF(6); addCopies(3); frm.push_back(8'h00); addCopies(13);
    sendFrame(1, 1, "R6 broken copy", 0);

    // R10: short sync and short copy count
    addFF(5); addCopies(16);
    sendFrame(1, 1, "R10 five sync bytes", 0);
    addFF(6); addCopies(15); addJunk(2);
    sendFrame(1, 1, "R10 fifteen copies", 0);

    // R7: unfinished frame then fresh frame with the remaining copies
    addFF(6); addCopies(8);
    sendFrame(1, 0, "", 0);
    addCopies(8); addJunk(1);
    sendFrame(1, 1, "R7 start resets state", 0);

    // R4: each enable low blocks detection
    magicEn = 1'b0;
    addFF(6); addCopies(16);
    sendFrame(1, 1, "R4 magicEn low", 0);
    magicEn = 1'b1; pmEn = 1'b0;
    addFF(6); addCopies(16);
    sendFrame(1, 1, "R4 pmEn low", 0);
    pmEn = 1'b1;

    // R5: address starting with 0xFF is matched as address byte
    stationAddr = 48'hFF_11_22_33_44_55;
    addJunk(3); addFF(6); addCopies(16); addJunk(1);
    sendFrame(1, 1, "R5 address begins with FF", 1);
    clearFlag("R8 clear after FF address");
    stationAddr = 48'h02_1A_3C_4D_5E_6F;

    // R9: software-only mode holds through pmEn low
    addFF(6); addCopies(16);
    sendFrame(1, 1, "R9 set before hold test", 1);
    @(negedge clk); pmEn = 1'b0;
    @(negedge clk); pushExp("R9 held with swOnly", 1);
    @(negedge clk); pmEn = 1'b1;
    // R9: other mode clears on pmEn low
    swOnly = 1'b0;
    @(negedge clk); pmEn = 1'b0;
    @(negedge clk); pushExp("R9 cleared by pmEn low", 0);
    @(negedge clk); pmEn = 1'b1; swOnly = 1'b1;

    repeat (4) @(negedge clk);
    finishRun();
  end

endmodule